// File: doc/BRIEF.md
# Mixed-Width Dual-Port Shared Memory

This block is a synchronous memory that two agents can use at the same time, each through its own port. Each port has an enable, a write strobe, an address, write data and registered read data. The two ports see the same storage at different word sizes. Storage is organised as a row of small units called atoms. A port whose width is K atoms sees the array as words of K atoms, so it has fewer addresses than a narrower port. A wide producer can therefore fill the memory in large words while a narrow consumer reads it back a byte at a time, or the other way round.

Both ports work on a single active clock edge. A parameter selects the rising or the falling edge. Reads complete one edge after the request. A port that writes returns the contents the location held before that write. When one port reads atoms that the other port writes in the same cycle, the write still lands, but the reading port's data is invalid for that result and its collision flag is raised. When both ports write overlapping atoms together, both flags are raised.

Top module: `mixed_width_dpram`

## Requirements
- R1: Port A is A_ATOMS atoms wide and port B is B_ATOMS atoms wide, with 8-bit atoms by default. Address n on a port of width K atoms covers atoms n*K to n*K+K-1 of the shared array. Atom n*K sits in the least significant 8 bits of that port's word, and higher atoms fill higher bits.
- R2: On an active edge where a port has en=1 and we=1, its write data is stored at the atoms its address covers. This is visible to both ports afterwards.
- R3: On an active edge where a port has en=1 and we=0, the contents at its address appear on its rdata output after that edge. The latency is one active edge.
- R4: While a port has en=0, it writes nothing, whatever its we and data are, and its rdata keeps its previous value.
- R5: A port that writes also updates its own rdata, and it shows the contents the location held before the write (read-first).
- R6: Both ports may read overlapping atoms in the same cycle. Each then returns the stored data, and neither collision flag is raised.
- R7: If one port reads while the other writes overlapping atoms in the same cycle, the write is stored. The reading port's collision flag is 1 for that result, and the writing port's flag stays 0.
- R8: A port's collision flag is 0 after any edge where that port is disabled or its atoms do not overlap an atom the other port writes. The flag therefore lasts exactly one result.
- R9: If both ports write overlapping atoms in the same cycle, both collision flags are 1 for that result.
- R10: With FALL_EDGE=1, every operation takes place on the falling clock edge, and the outputs do not change at the rising edge.
- R11: While rst_n is low, both rdata outputs and both collision flags are 0. The stored contents are not reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | $clog2(DEPTH_ATOMS/A_ATOMS) | Port A word address |
| a_wdata | input | ATOM_W*A_ATOMS | Port A write data |
| a_rdata | output | ATOM_W*A_ATOMS | Port A registered read data |
| a_collide | output | 1 | Port A result was invalidated by a collision |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | $clog2(DEPTH_ATOMS/B_ATOMS) | Port B word address |
| b_wdata | input | ATOM_W*B_ATOMS | Port B write data |
| b_rdata | output | ATOM_W*B_ATOMS | Port B registered read data |
| b_collide | output | 1 | Port B result was invalidated by a collision |

## Verification
Every result of this block, read data and collision flags alike, is due exactly one active edge after the cycle that requested it. A write becomes readable through either port starting with the next request. The bench applies each request at the opposite clock edge, lets exactly one active edge pass, and samples at the following opposite edge, so each check sees the result of one request only. For the falling-edge instance, the bench drives at the rising edge. It samples once shortly after that edge, to confirm nothing has moved yet, and again a full period later.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    // True when atom span [a_lo, a_lo+a_n) shares at least one atom with [b_lo, b_lo+b_n)
    function automatic logic spans_meet(input int a_lo, input int a_n,
                                        input int b_lo, input int b_n);
        return (a_lo < b_lo + b_n) && (b_lo < a_lo + a_n);
    endfunction

endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter  int ATOM_W      = 8,
    parameter  int DEPTH_ATOMS = 64,
    parameter  int A_K         = 4,
    parameter  int B_K         = 1,
    localparam int ATOM_AW     = $clog2(DEPTH_ATOMS),
    localparam int A_W         = ATOM_W * A_K,
    localparam int B_W         = ATOM_W * B_K
) (
    input  logic               clk_act,
    input  logic               a_wr,
    input  logic [ATOM_AW-1:0] a_base,
    input  logic [A_W-1:0]     a_wdata,
    output logic [A_W-1:0]     a_mem_rd,
    input  logic               b_wr,
    input  logic [ATOM_AW-1:0] b_base,
    input  logic [B_W-1:0]     b_wdata,
    output logic [B_W-1:0]     b_mem_rd
);

    logic [ATOM_W-1:0] atoms [DEPTH_ATOMS];

    // Port B is applied after port A; overlapping double writes are flagged as undefined
    always_ff @(posedge clk_act) begin
        if (a_wr) begin
            for (int i = 0; i < A_K; i++) begin
                atoms[a_base + ATOM_AW'(i)] <= a_wdata[i*ATOM_W +: ATOM_W];
            end
        end
        if (b_wr) begin
            for (int i = 0; i < B_K; i++) begin
                atoms[b_base + ATOM_AW'(i)] <= b_wdata[i*ATOM_W +: ATOM_W];
            end
        end
    end

    // Combinational view of the pre-edge contents gives read-first behaviour
    always_comb begin
        for (int i = 0; i < A_K; i++) begin
            a_mem_rd[i*ATOM_W +: ATOM_W] = atoms[a_base + ATOM_AW'(i)];
        end
    end

    always_comb begin
        for (int i = 0; i < B_K; i++) begin
            b_mem_rd[i*ATOM_W +: ATOM_W] = atoms[b_base + ATOM_AW'(i)];
        end
    end

endmodule

// File: rtl/dpr_collide.sv
module dpr_collide
    import dpr_pkg::*;
#(
    parameter  int DEPTH_ATOMS = 64,
    parameter  int A_K         = 4,
    parameter  int B_K         = 1,
    localparam int ATOM_AW     = $clog2(DEPTH_ATOMS)
) (
    input  logic               a_rd,
    input  logic               a_wr,
    input  logic [ATOM_AW-1:0] a_base,
    input  logic               b_rd,
    input  logic               b_wr,
    input  logic [ATOM_AW-1:0] b_base,
    output logic               a_rd_hit,
    output logic               b_rd_hit,
    output logic               ww_hit
);

    logic meet;

    always_comb begin
        meet     = spans_meet(int'(a_base), A_K, int'(b_base), B_K);
        a_rd_hit = meet && a_rd && b_wr;
        b_rd_hit = meet && b_rd && a_wr;
        ww_hit   = meet && a_wr && b_wr;
    end

endmodule

// File: rtl/dpr_lane.sv
module dpr_lane
    import dpr_pkg::*;
#(
    parameter  int ATOM_W      = 8,
    parameter  int K           = 4,
    parameter  int DEPTH_ATOMS = 64,
    localparam int W           = ATOM_W * K,
    localparam int DEPTH       = DEPTH_ATOMS / K,
    localparam int AW          = $clog2(DEPTH),
    localparam int ATOM_AW     = $clog2(DEPTH_ATOMS)
) (
    input  logic               clk_act,
    input  logic               rst_n,
    input  logic               en,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [W-1:0]       mem_rd,
    input  logic               rd_hit,
    input  logic               ww_hit,
    output logic [ATOM_AW-1:0] base,
    output logic               rd,
    output logic               wr,
    output logic [W-1:0]       rdata,
    output logic               collide
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         collide;
    } lane_t;

    port_op_e op;
    lane_t    st_d, st_q;

    always_comb begin
        if (!en)     op = OP_IDLE;
        else if (we) op = OP_WRITE;
        else         op = OP_READ;
        base = ATOM_AW'(addr) * ATOM_AW'(K);
        rd   = (op == OP_READ);
        wr   = (op == OP_WRITE);
    end

    always_comb begin
        st_d         = st_q;
        st_d.collide = 1'b0;
        case (op)
            OP_READ: begin
                st_d.data    = rd_hit ? {W{1'bx}} : mem_rd;
                st_d.collide = rd_hit;
            end
            OP_WRITE: begin
                st_d.data    = mem_rd;
                st_d.collide = ww_hit;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_act or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = st_q.data;
    assign collide = st_q.collide;

    p_idle_hold_r4: assert property (@(posedge clk_act) disable iff (!rst_n)
        !en |=> $stable(rdata))
        else $error("disabled port changed its read data");

    p_idle_quiet_r8: assert property (@(posedge clk_act) disable iff (!rst_n)
        !en |=> !collide)
        else $error("disabled port raised a collision");

endmodule

// File: rtl/mixed_width_dpram.sv
module mixed_width_dpram #(
    parameter  int ATOM_W      = 8,
    parameter  int A_ATOMS     = 4,
    parameter  int B_ATOMS     = 1,
    parameter  int DEPTH_ATOMS = 64,
    parameter  bit FALL_EDGE   = 1'b0,
    localparam int A_W         = ATOM_W * A_ATOMS,
    localparam int B_W         = ATOM_W * B_ATOMS,
    localparam int A_AW        = $clog2(DEPTH_ATOMS / A_ATOMS),
    localparam int B_AW        = $clog2(DEPTH_ATOMS / B_ATOMS),
    localparam int ATOM_AW     = $clog2(DEPTH_ATOMS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            a_en,
    input  logic            a_we,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_W-1:0]  a_wdata,
    output logic [A_W-1:0]  a_rdata,
    output logic            a_collide,
    input  logic            b_en,
    input  logic            b_we,
    input  logic [B_AW-1:0] b_addr,
    input  logic [B_W-1:0]  b_wdata,
    output logic [B_W-1:0]  b_rdata,
    output logic            b_collide
);

    logic               clk_act;
    logic [ATOM_AW-1:0] a_base, b_base;
    logic               a_rd, a_wr, b_rd, b_wr;
    logic               a_rd_hit, b_rd_hit, ww_hit;
    logic [A_W-1:0]     a_mem_rd;
    logic [B_W-1:0]     b_mem_rd;

    if (FALL_EDGE) begin : g_fall
        assign clk_act = ~clk;
    end else begin : g_rise
        assign clk_act = clk;
    end

    dpr_lane #(.ATOM_W(ATOM_W), .K(A_ATOMS), .DEPTH_ATOMS(DEPTH_ATOMS)) u_lane_a (
        .clk_act(clk_act), .rst_n(rst_n), .en(a_en), .we(a_we), .addr(a_addr),
        .mem_rd(a_mem_rd), .rd_hit(a_rd_hit), .ww_hit(ww_hit),
        .base(a_base), .rd(a_rd), .wr(a_wr), .rdata(a_rdata), .collide(a_collide)
    );

    dpr_lane #(.ATOM_W(ATOM_W), .K(B_ATOMS), .DEPTH_ATOMS(DEPTH_ATOMS)) u_lane_b (
        .clk_act(clk_act), .rst_n(rst_n), .en(b_en), .we(b_we), .addr(b_addr),
        .mem_rd(b_mem_rd), .rd_hit(b_rd_hit), .ww_hit(ww_hit),
        .base(b_base), .rd(b_rd), .wr(b_wr), .rdata(b_rdata), .collide(b_collide)
    );

    dpr_collide #(.DEPTH_ATOMS(DEPTH_ATOMS), .A_K(A_ATOMS), .B_K(B_ATOMS)) u_collide (
        .a_rd(a_rd), .a_wr(a_wr), .a_base(a_base),
        .b_rd(b_rd), .b_wr(b_wr), .b_base(b_base),
        .a_rd_hit(a_rd_hit), .b_rd_hit(b_rd_hit), .ww_hit(ww_hit)
    );

    dpr_store #(.ATOM_W(ATOM_W), .DEPTH_ATOMS(DEPTH_ATOMS), .A_K(A_ATOMS), .B_K(B_ATOMS)) u_store (
        .clk_act(clk_act),
        .a_wr(a_wr), .a_base(a_base), .a_wdata(a_wdata), .a_mem_rd(a_mem_rd),
        .b_wr(b_wr), .b_base(b_base), .b_wdata(b_wdata), .b_mem_rd(b_mem_rd)
    );

    p_double_write_r9: assert property (@(posedge clk_act) disable iff (!rst_n)
        (a_collide && b_collide) |-> $past(a_en && a_we && b_en && b_we))
        else $error("both flags raised without a double write");

    p_b_reader_r7: assert property (@(posedge clk_act) disable iff (!rst_n)
        (b_collide && !a_collide) |-> $past(a_en && a_we && b_en && !b_we))
        else $error("port B flag without a port A write");

    p_a_reader_r7: assert property (@(posedge clk_act) disable iff (!rst_n)
        (a_collide && !b_collide) |-> $past(b_en && b_we && a_en && !a_we))
        else $error("port A flag without a port B write");

endmodule

// File: tb/mixed_width_dpram_bench.sv
`timescale 1ns/1ps
module mixed_width_dpram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [3:0]  a_addr = '0;
    logic [31:0] a_wdata = '0, a_rdata;
    logic [5:0]  b_addr = '0;
    logic [7:0]  b_wdata = '0, b_rdata;
    logic        a_collide, b_collide;

    logic        f_a_en = 0, f_a_we = 0, f_b_en = 0, f_b_we = 0;
    logic [3:0]  f_a_addr = '0;
    logic [31:0] f_a_wdata = '0, f_a_rdata;
    logic [5:0]  f_b_addr = '0;
    logic [7:0]  f_b_wdata = '0, f_b_rdata;
    logic        f_a_collide, f_b_collide;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [64];

    always #2.5 clk = ~clk;

    mixed_width_dpram u_mixed_width_dpram (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_collide(a_collide),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_collide(b_collide)
    );

    mixed_width_dpram #(.FALL_EDGE(1'b1)) u_mixed_width_dpram_fall (
        .clk(clk), .rst_n(rst_n),
        .a_en(f_a_en), .a_we(f_a_we), .a_addr(f_a_addr), .a_wdata(f_a_wdata),
        .a_rdata(f_a_rdata), .a_collide(f_a_collide),
        .b_en(f_b_en), .b_we(f_b_we), .b_addr(f_b_addr), .b_wdata(f_b_wdata),
        .b_rdata(f_b_rdata), .b_collide(f_b_collide)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int w);
        return {model[4*w+3], model[4*w+2], model[4*w+1], model[4*w]};
    endfunction

    // Called at a falling edge: apply, let one rising edge pass, return at the next falling edge
    task automatic op(input logic ae, input logic awe, input logic [3:0] aa, input logic [31:0] ad,
                      input logic be, input logic bwe, input logic [5:0] ba, input logic [7:0] bd);
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        @(negedge clk);
    endtask

    task automatic put_word(input int w, input logic [31:0] v);
        for (int k = 0; k < 4; k++) model[4*w+k] = v[8*k +: 8];
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R11: outputs cleared during reset
        chk("R11 a_rdata", a_rdata, 32'h0);
        chk("R11 b_rdata", {24'h0, b_rdata}, 32'h0);
        chk("R11 flags", {30'h0, a_collide, b_collide}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R1: narrow writes, wide reads assemble atoms low to high
        for (int i = 0; i < 64; i++) begin
            op(0, 0, 0, 0, 1, 1, 6'(i), 8'((i * 37 + 5) & 8'hFF));
            model[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        for (int w = 0; w < 16; w++) begin
            op(1, 0, 4'(w), 0, 0, 0, 0, 0);
            chk("R1 R3 wide read of narrow writes", a_rdata, word_of(w));
        end
        // R2, R3: wide writes, narrow reads
        for (int w = 0; w < 16; w++) begin
            v = 32'h9E3779B9 * 32'(w + 1);
            op(1, 1, 4'(w), v, 0, 0, 0, 0);
            put_word(w, v);
        end
        for (int i = 0; i < 64; i++) begin
            op(0, 0, 0, 0, 1, 0, 6'(i), 0);
            chk("R1 R2 narrow read of wide writes", {24'h0, b_rdata}, {24'h0, model[i]});
        end

        // R4: disabled ports neither write nor change rdata
        op(1, 0, 4'd0, 0, 0, 0, 0, 0);
        op(0, 1, 4'd0, 32'hDEADBEEF, 0, 1, 6'd0, 8'hFF);
        chk("R4 rdata hold", a_rdata, word_of(0));
        op(0, 0, 4'd5, 0, 0, 0, 6'd7, 0);
        chk("R4 rdata hold idle", a_rdata, word_of(0));
        op(1, 0, 4'd0, 0, 1, 0, 6'd0, 0);
        chk("R4 no write A", a_rdata, word_of(0));
        chk("R4 no write B", {24'h0, b_rdata}, {24'h0, model[0]});

        // R5: read-first on the writing port
        op(1, 1, 4'd2, 32'h0BADF00D, 0, 0, 0, 0);
        chk("R5 A old data", a_rdata, word_of(2));
        put_word(2, 32'h0BADF00D);
        op(0, 0, 0, 0, 1, 1, 6'd9, 8'h5A);
        chk("R5 B old data", {24'h0, b_rdata}, {24'h0, model[9]});
        model[9] = 8'h5A;
        op(1, 0, 4'd2, 0, 1, 0, 6'd9, 0);
        chk("R5 A new data", a_rdata, word_of(2));
        chk("R5 B new data", {24'h0, b_rdata}, 32'h5A);

        // R6: overlapping reads
        op(1, 0, 4'd3, 0, 1, 0, 6'd13, 0);
        chk("R6 A data", a_rdata, word_of(3));
        chk("R6 B data", {24'h0, b_rdata}, {24'h0, model[13]});
        chk("R6 flags", {30'h0, a_collide, b_collide}, 32'h0);

        // R7: A writes while B reads inside the word
        v = word_of(5);
        op(1, 1, 4'd5, 32'h13579BDF, 1, 0, 6'd21, 0);
        chk("R7 B flag", {31'h0, b_collide}, 32'h1);
        chk("R7 A flag", {31'h0, a_collide}, 32'h0);
        chk("R7 A old data", a_rdata, v);
        put_word(5, 32'h13579BDF);
        op(1, 0, 4'd5, 0, 1, 0, 6'd21, 0);
        chk("R7 write landed", a_rdata, 32'h13579BDF);
        chk("R7 B reads new", {24'h0, b_rdata}, 32'h9B);
        chk("R8 flags pulse", {30'h0, a_collide, b_collide}, 32'h0);

        // R7: B writes while A reads
        op(1, 0, 4'd6, 0, 1, 1, 6'd24, 8'hC7);
        chk("R7 A flag", {31'h0, a_collide}, 32'h1);
        chk("R7 B flag", {31'h0, b_collide}, 32'h0);
        chk("R7 B old data", {24'h0, b_rdata}, {24'h0, model[24]});
        model[24] = 8'hC7;
        op(1, 0, 4'd6, 0, 0, 0, 0, 0);
        chk("R7 byte landed", a_rdata, word_of(6));

        // R8: no overlap, and disabled reader, give no flag
        op(1, 1, 4'd7, 32'h2468ACE0, 1, 0, 6'd0, 0);
        put_word(7, 32'h2468ACE0);
        chk("R8 disjoint flags", {30'h0, a_collide, b_collide}, 32'h0);
        chk("R8 disjoint B data", {24'h0, b_rdata}, {24'h0, model[0]});
        op(1, 1, 4'd9, 32'h11111111, 0, 0, 6'd36, 0);
        put_word(9, 32'h11111111);
        chk("R8 disabled B flag", {31'h0, b_collide}, 32'h0);

        // R9: overlapping double write
        op(1, 1, 4'd8, 32'hAAAAAAAA, 1, 1, 6'd33, 8'h55);
        chk("R9 both flags", {30'h0, a_collide, b_collide}, 32'h3);
        op(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 flags clear", {30'h0, a_collide, b_collide}, 32'h0);

        // R10: falling-edge instance, driven at rising edges
        @(posedge clk);
        f_a_en = 1; f_a_we = 1; f_a_addr = 4'd1; f_a_wdata = 32'h11223344;
        @(posedge clk);
        f_a_en = 0; f_a_we = 0;
        f_b_en = 1; f_b_addr = 6'd6;
        #1;
        chk("R10 no change at rising edge", {24'h0, f_b_rdata}, 32'h0);
        @(posedge clk);
        f_b_en = 0;
        #1;
        chk("R10 read at falling edge", {24'h0, f_b_rdata}, 32'h22);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule